// File: doc/BRIEF.md
# Half-Time Match Stopwatch

This block keeps the elapsed playing time of one half of a football match. It runs from a 100 MHz system clock and divides it down to a one-second step. It presents the time as four BCD digits: minutes tens, minutes units, seconds tens and seconds units. A run switch lets the time advance. A hold switch freezes the time and can be released to carry on from the frozen value. A synchronous reset button returns the time to 00:00.

The time stops by itself at 45:00 and stays there while the run switch remains on. A flag reports that the half is over. The only way to leave 45:00 and time the next half is a reset. The inputs arrive already synchronised and debounced. The digits are meant for a display driver placed next to this block.

The prescaler length is a parameter, `TICK_DIV`. Its default gives one step per second at 100 MHz. A bench can set it to a few cycles so that a whole half fits in a short run.

Top module: `match_clock`

## Requirements
- R1: While `rst` is high at a clock edge, all four digits become 0 and `half_done` becomes 0. This holds whatever `run_sw` and `hold_sw` are doing. Reset also clears the prescaler, so the first step after reset is released needs a full `TICK_DIV` running cycles.
- R2: The time advances only in cycles where `run_sw` is 1. While `run_sw` is 0, the time is held and the prescaler keeps its partial count.
- R3: `hold_sw` = 1 takes priority over `run_sw`. It freezes the time and clears the prescaler to zero. Counting resumes from the frozen time once `hold_sw` returns to 0.
- R4: One second of match time takes exactly `TICK_DIV` running cycles. A running cycle is one where `run_sw`=1, `hold_sw`=0, `rst`=0 and the half is not over. The default `TICK_DIV` is 100,000,000.
- R5: Seconds count in BCD from 00 to 59. The step after 59 sets the seconds to 00 and adds one to the minutes.
- R6: Minutes count in BCD. When the time reaches 45:00 it stops and stays at 45:00 while `run_sw` stays on, until a reset.
- R7: `half_done` is 1 exactly while the time reads 45:00. It rises on the step from 44:59.
- R8: Each digit always holds a valid BCD value. The seconds tens digit never exceeds 5, and the minutes tens digit never exceeds 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 100 MHz |
| rst | input | 1 | Synchronous reset button, active high |
| run_sw | input | 1 | Run switch; time may advance while 1 |
| hold_sw | input | 1 | Hold switch; freezes time, overrides run |
| min_tens | output | 4 | Minutes tens digit, BCD |
| min_ones | output | 4 | Minutes units digit, BCD |
| sec_tens | output | 4 | Seconds tens digit, BCD |
| sec_ones | output | 4 | Seconds units digit, BCD |
| half_done | output | 1 | High while the time reads 45:00 |

## Verification
The hardest state to reach from the ports is the partial prescaler count that a stopped run switch leaves behind. The bench has to tell it apart from the cleared count that a hold leaves. To do this it stops each phase part-way through a second and then counts the running cycles to the next step. That count differs by whole cycles depending on whether the partial count was kept or cleared. The bench also runs with a prescaler of four cycles, which lets it walk through all 2700 steps to 45:00. It checks 44:59 just before the stop and then holds the run switch on well past it.

// File: rtl/match_clock.sv
module match_clock #(
  parameter int unsigned TICK_DIV = 100_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run_sw,
  input  logic       hold_sw,
  output logic [3:0] min_tens,
  output logic [3:0] min_ones,
  output logic [3:0] sec_tens,
  output logic [3:0] sec_ones,
  output logic       half_done
);

  localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre_q;
  logic at_end, active, tick;

  assign at_end = (min_tens == 4'd4) && (min_ones == 4'd5) &&
                  (sec_tens == 4'd0) && (sec_ones == 4'd0);
  assign active = run_sw && !hold_sw && !at_end;
  assign tick   = active && (pre_q == PRE_LAST);
  assign half_done = at_end;

  always_ff @(posedge clk) begin
    if (rst || hold_sw || tick) pre_q <= '0;
    else if (active)            pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      min_tens <= '0;
      min_ones <= '0;
      sec_tens <= '0;
      sec_ones <= '0;
    end else if (tick) begin
      if (sec_ones != 4'd9) begin
        sec_ones <= sec_ones + 4'd1;
      end else begin
        sec_ones <= '0;
        if (sec_tens != 4'd5) begin
          sec_tens <= sec_tens + 4'd1;
        end else begin
          sec_tens <= '0;
          if (min_ones != 4'd9) begin
            min_ones <= min_ones + 4'd1;
          end else begin
            min_ones <= '0;
            min_tens <= min_tens + 4'd1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/match_clock_chk.sv
module match_clock_chk (
  input logic       clk,
  input logic       rst,
  input logic       run_sw,
  input logic       hold_sw,
  input logic [3:0] min_tens,
  input logic [3:0] min_ones,
  input logic [3:0] sec_tens,
  input logic [3:0] sec_ones,
  input logic       half_done
);

  logic [15:0] t;
  logic rst_d;
  assign t = {min_tens, min_ones, sec_tens, sec_ones};

  always_ff @(posedge clk) rst_d <= rst;

  p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
    rst_d |-> (t == 16'h0000) && !half_done);

  p_idle_freeze_r2: assert property (@(posedge clk) disable iff (rst)
    !run_sw |=> $stable(t));

  p_hold_freeze_r3: assert property (@(posedge clk) disable iff (rst)
    hold_sw |=> $stable(t));

  p_done_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    half_done |=> half_done && $stable(t));

  p_done_entry_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(half_done) |-> $past(t) == 16'h4459);

  always_ff @(posedge clk) begin
    if (!rst && !rst_d) begin
      p_bcd_digits_r8: assert (sec_ones <= 4'd9 && sec_tens <= 4'd5 &&
                               min_ones <= 4'd9 && min_tens <= 4'd4);
    end
  end

endmodule

bind match_clock match_clock_chk chk_i (.*);

// File: tb/match_clock_tb_top.sv
module match_clock_tb_top;

  localparam int unsigned DIV = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_sw = 1'b0;
  logic hold_sw = 1'b0;
  logic [3:0] min_tens, min_ones, sec_tens, sec_ones;
  logic half_done;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  match_clock #(.TICK_DIV(DIV)) dut_i (
    .clk(clk), .rst(rst), .run_sw(run_sw), .hold_sw(hold_sw),
    .min_tens(min_tens), .min_ones(min_ones),
    .sec_tens(sec_tens), .sec_ones(sec_ones), .half_done(half_done)
  );

  // {run, hold, cycles[15:0], expected mm:ss BCD[15:0]}
  localparam logic [33:0] VEC [9] = '{
    {1'b1, 1'b0, 16'd6,    16'h0001},  // R4 one step, prescaler left at 2
    {1'b1, 1'b1, 16'd10,   16'h0001},  // R3 hold over run, prescaler cleared
    {1'b1, 1'b0, 16'd6,    16'h0002},  // R3 only one step after clear
    {1'b0, 1'b0, 16'd20,   16'h0002},  // R2 run off holds time
    {1'b1, 1'b0, 16'd2,    16'h0003},  // R2 partial count kept
    {1'b0, 1'b1, 16'd4,    16'h0003},  // R3 hold alone
    {1'b1, 1'b0, 16'd224,  16'h0059},  // R5 up to 59 s
    {1'b1, 1'b0, 16'd4,    16'h0100},  // R5 wrap into minutes
    {1'b1, 1'b0, 16'd2400, 16'h1100}   // R5 minute units wrap
  };

  task automatic check(input string req, input logic [15:0] exp_t, input logic exp_d);
    logic [15:0] got;
    got = {min_tens, min_ones, sec_tens, sec_ones};
    n_chk++;
    if (got !== exp_t || half_done !== exp_d) begin
      n_fail++;
      $display("FAIL %s: got %h done=%b, expected %h done=%b", req, got, half_done, exp_t, exp_d);
    end
  endtask

  task automatic run_for(input logic r, input logic h, input int n);
    run_sw = r;
    hold_sw = h;
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset state", 16'h0000, 1'b0);
    rst = 1'b0;
    for (int i = 0; i < 9; i++) begin
      run_for(VEC[i][33], VEC[i][32], int'(VEC[i][31:16]));
      check($sformatf("vector %0d (R2-R5 table)", i), VEC[i][15:0], 1'b0);
    end
    // R6: 11:00 to 44:59 is 2039 s
    run_for(1'b1, 1'b0, 2039 * DIV);
    check("R6 at 44:59", 16'h4459, 1'b0);
    run_for(1'b1, 1'b0, DIV - 1);
    check("R4 partial second before end", 16'h4459, 1'b0);
    run_for(1'b1, 1'b0, 1);
    check("R7 reach 45:00", 16'h4500, 1'b1);
    run_for(1'b1, 1'b0, 40 * DIV);
    check("R6 frozen at 45:00", 16'h4500, 1'b1);
    // R1: reset beats run
    rst = 1'b1;
    run_for(1'b1, 1'b0, 2);
    check("R1 reset from end", 16'h0000, 1'b0);
    rst = 1'b0;
    run_for(1'b1, 1'b0, 5);
    check("R4 first step after reset", 16'h0001, 1'b0);
    run_for(1'b1, 1'b0, DIV - 2);
    check("R1 prescaler cleared by reset", 16'h0001, 1'b0);
    rst = 1'b1;
    run_for(1'b1, 1'b1, 2);
    check("R1 reset beats hold", 16'h0000, 1'b0);
    rst = 1'b0;
    run_for(1'b1, 1'b0, DIV - 1);
    check("R1 no step before full count", 16'h0000, 1'b0);
    run_for(1'b1, 1'b0, 1);
    check("R8 digits after restart", 16'h0001, 1'b0);
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule